// File: doc/BRIEF.md
# Registered 16-bit Multifunction ALU

This block is a two-stage arithmetic and logic unit for 16-bit data. On one rising clock edge it captures operand A, operand B and a 3-bit function code into input registers. Between those registers and a 16-bit result register sit five function units: an adder/subtractor, a bitwise AND, a bitwise OR, a left shifter and a multiplier that keeps the low half of the product. The function code drives an eight-way selector that picks one unit's output, or a constant zero. The selected value is written into the result register on the next rising edge.

A carry flag is registered next to the result. It is meaningful only for addition and subtraction and reads 0 for every other function. Because each edge starts a new operation while the previous one is written out, a caller can issue one operation per clock and read each answer two edges after it was presented. An active-low synchronous reset clears all state.

Top module: `mfalu16`

## Requirements
- R1: While `rst_n` is low at a rising edge, the operand, code, result and carry registers clear, so `result_q` = 0 and `carry_q` = 0 after that edge. The first result after reset is also 0.
- R2: The inputs present at rising edge k decide `result_q` and `carry_q` after edge k+1. The outputs after edge k still belong to the previous operation.
- R3: Code 000 gives A + B modulo 2^16, and `carry_q` is bit 16 of the full sum. For example, 0x7FFF + 0x0001 gives 0x8000 with carry 0, and 0xFFFF + 0x0001 gives 0x0000 with carry 1.
- R4: Code 011 gives A − B, computed as A + ~B + 1. `carry_q` is the carry out of that sum, so it is 1 exactly when A ≥ B as unsigned numbers. Equal operands give 0x0000 with carry 1.
- R5: Code 001 returns A unchanged. B is ignored.
- R6: Code 010 returns the bitwise OR of A and B.
- R7: Code 110 returns the bitwise AND of A and B.
- R8: Code 100 shifts A left by the amount in B[1:0] (0 to 3 places) and fills with zeros from the right. B[15:2] is ignored.
- R9: Code 101 multiplies A by B as unsigned 16-bit values and returns bits [15:0] of the 32-bit product.
- R10: Code 111 returns 0x0000 whatever the operands are.
- R11: `carry_q` is 0 after any operation whose code is not 000 or 011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. All registers capture on the rising edge. |
| rst_n | input | 1 | Synchronous reset, active low. |
| a_in | input | 16 | Operand A. |
| b_in | input | 16 | Operand B. B[1:0] is the shift amount for code 100. |
| op_in | input | 3 | Function code. |
| result_q | output | 16 | Registered result. |
| carry_q | output | 1 | Registered carry from add or subtract. Reads 0 for every other code. |

## Verification
On every edge the block writes out one operation's result while it captures the next operation's operands and code. Both happen in the same cycle. The bench provokes this by changing the code and the operands on every cycle: first in a directed list of corner cases, then in a long pseudo-random stream, with one reset pulse placed in the middle of the stream. A queue-style reference model in the bench holds each operation's expected value for one extra edge. That model is compared with the outputs on every cycle, so any answer that mixes two neighbouring operations fails the comparison. The bench also checks once, explicitly, that an answer is not visible one edge early.

// File: rtl/mfalu_pkg.sv
// Package: shared definitions for the registered multifunction ALU.
// Assumes: a 3-bit function code. The code values are fixed and
// external callers depend on them.
package mfalu_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'b000,
        OP_PASS = 3'b001,
        OP_OR   = 3'b010,
        OP_SUB  = 3'b011,
        OP_SHL  = 3'b100,
        OP_MUL  = 3'b101,
        OP_AND  = 3'b110,
        OP_ZERO = 3'b111
    } op_e;

endpackage

// File: rtl/mfalu_capture.sv
// Module: input stage. Registers operand A, operand B and the function code.
// Assumes: synchronous active-low reset. All state clears to zero,
// and a zero code selects addition.
module mfalu_capture
    import mfalu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_d,
    input  logic [W-1:0] b_d,
    input  op_e          op_d,
    output logic [W-1:0] a_q,
    output logic [W-1:0] b_q,
    output op_e          op_q
);

    // Capture the operands and the code on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q  <= '0;
            b_q  <= '0;
            op_q <= OP_ADD;
        end else begin
            a_q  <= a_d;
            b_q  <= b_d;
            op_q <= op_d;
        end
    end

endmodule

// File: rtl/mfalu_addsub.sv
// Module: ripple adder/subtractor with carry out.
// Assumes: subtraction is done as a + ~b + 1. The carry out is the true
// carry of that sum, so it is 1 when a >= b (unsigned).
module mfalu_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W:0] total;

    // Invert B when subtracting and inject the carry-in.
    always_comb begin
        total = {1'b0, a} + {1'b0, b ^ {W{sub}}} + {{W{1'b0}}, sub};
        sum   = total[W-1:0];
        cout  = total[W];
    end

endmodule

// File: rtl/mfalu_shl.sv
// Module: logical left shifter with a small shift amount.
// Assumes: the amount is SHW bits wide and zeros enter from the right.
// One mux level is built per amount bit.
module mfalu_shl #(
    parameter int W   = 16,
    parameter int SHW = 2
) (
    input  logic [W-1:0]   a,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   y
);

    logic [W-1:0] lvl [SHW+1];

    assign lvl[0] = a;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int DIST = 1 << s;
        // Shift by 2^s when amount bit s is set.
        assign lvl[s+1] = amt[s] ? {lvl[s][W-1-DIST:0], {DIST{1'b0}}} : lvl[s];
    end

    assign y = lvl[SHW];

endmodule

// File: rtl/mfalu_mul.sv
// Module: unsigned array multiplier that keeps only the low W bits.
// Assumes: full W-bit operands. Product bits at or above W are dropped,
// so each row adder only needs W bits.
module mfalu_mul #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] p
);

    logic [W-1:0] row [W+1];

    assign row[0] = '0;

    for (genvar r = 0; r < W; r++) begin : g_row
        // Add the shifted copy of A when bit r of B is set.
        assign row[r+1] = row[r] + (b[r] ? (a << r) : {W{1'b0}});
    end

    assign p = row[W];

endmodule

// File: rtl/mfalu16.sv
// Module: top of the registered multifunction ALU.
// Assumes: one operation can start every clock. A result appears two
// rising edges after its inputs are presented. The carry is meaningful
// only for add and subtract and is forced to 0 for every other code.
module mfalu16
    import mfalu_pkg::*;
#(
    parameter int W   = 16,
    parameter int SHW = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [2:0]   op_in,
    output logic [W-1:0] result_q,
    output logic         carry_q
);

    logic [W-1:0] a_q, b_q;
    op_e          op_q;
    logic [W-1:0] sum_w, shl_w, mul_w;
    logic         cout_w, is_sub;
    logic [W-1:0] res_d;
    logic         carry_d;

    mfalu_capture #(.W(W)) u_cap (
        .clk  (clk),
        .rst_n(rst_n),
        .a_d  (a_in),
        .b_d  (b_in),
        .op_d (op_e'(op_in)),
        .a_q  (a_q),
        .b_q  (b_q),
        .op_q (op_q)
    );

    assign is_sub = (op_q == OP_SUB);

    mfalu_addsub #(.W(W)) u_add (
        .a   (a_q),
        .b   (b_q),
        .sub (is_sub),
        .sum (sum_w),
        .cout(cout_w)
    );

    mfalu_shl #(.W(W), .SHW(SHW)) u_shl (
        .a  (a_q),
        .amt(b_q[SHW-1:0]),
        .y  (shl_w)
    );

    mfalu_mul #(.W(W)) u_mul (
        .a(a_q),
        .b(b_q),
        .p(mul_w)
    );

    // Pick one unit's output according to the registered code.
    always_comb begin
        carry_d = 1'b0;
        unique case (op_q)
            OP_ADD:  begin res_d = sum_w; carry_d = cout_w; end
            OP_SUB:  begin res_d = sum_w; carry_d = cout_w; end
            OP_PASS: res_d = a_q;
            OP_OR:   res_d = a_q | b_q;
            OP_AND:  res_d = a_q & b_q;
            OP_SHL:  res_d = shl_w;
            OP_MUL:  res_d = mul_w;
            OP_ZERO: res_d = '0;
            default: res_d = '0;
        endcase
    end

    // Register the selected result and the carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            carry_q  <= 1'b0;
        end else begin
            result_q <= res_d;
            carry_q  <= carry_d;
        end
    end

endmodule

// File: rtl/mfalu16_chk.sv
// Module: assertion checker for mfalu16, attached with bind.
// Assumes: only the ports are observed. A small counter makes sure a
// property looks back only over edges taken since reset.
module mfalu16_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [2:0]   op_in,
    input logic [W-1:0] result_q,
    input logic         carry_q
);

    logic [1:0] live;

    // Count the consecutive non-reset edges, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)         live <= 2'd0;
        else if (live != 2) live <= live + 2'd1;
    end

    // R1: reset clears the outputs
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (result_q == '0 && carry_q == 1'b0));

    // R11: no carry for non-arithmetic codes
    a_r11_carry_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (live == 2 && $past(op_in, 2) != 3'b000 && $past(op_in, 2) != 3'b011)
        |-> carry_q == 1'b0);

    // R4: equal operands subtract to zero with carry set
    a_r4_sub_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (live == 2 && $past(op_in, 2) == 3'b011 && $past(a_in, 2) == $past(b_in, 2))
        |-> (result_q == '0 && carry_q == 1'b1));

    // R5 and R2: pass of A, two edges later
    a_r5_pass_a: assert property (@(posedge clk) disable iff (!rst_n)
        (live == 2 && $past(op_in, 2) == 3'b001) |-> result_q == $past(a_in, 2));

    // R7: bitwise AND
    a_r7_and: assert property (@(posedge clk) disable iff (!rst_n)
        (live == 2 && $past(op_in, 2) == 3'b110)
        |-> result_q == ($past(a_in, 2) & $past(b_in, 2)));

    // R6: bitwise OR
    a_r6_or: assert property (@(posedge clk) disable iff (!rst_n)
        (live == 2 && $past(op_in, 2) == 3'b010)
        |-> result_q == ($past(a_in, 2) | $past(b_in, 2)));

    // R10: zero code
    a_r10_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (live == 2 && $past(op_in, 2) == 3'b111) |-> result_q == '0);

endmodule

bind mfalu16 mfalu16_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_in    (a_in),
    .b_in    (b_in),
    .op_in   (op_in),
    .result_q(result_q),
    .carry_q (carry_q)
);

// File: tb/mfalu16_test.sv
// Bench: behavioural reference model compared with the outputs on every clock.
module mfalu16_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a_in = '0;
    logic [15:0] b_in = '0;
    logic [2:0]  op_in = '0;
    logic [15:0] result_q;
    logic        carry_q;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    bit started = 0;

    // Model state: value pending one edge, and the value now expected.
    bit [15:0] pend_res, exp_res;
    bit        pend_c, exp_c;
    string     pend_tag, exp_tag;

    mfalu16 uut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .op_in(op_in), .result_q(result_q), .carry_q(carry_q)
    );

    always #2 clk = ~clk;

    function automatic string tag_of(input bit [2:0] op);
        case (op)
            3'd0: return "R3";
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R4";
            3'd4: return "R8";
            3'd5: return "R9";
            3'd6: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic model(input bit [2:0] op, input bit [15:0] a, input bit [15:0] b,
                         output bit [15:0] r, output bit c);
        bit [31:0] t;
        c = 0;
        case (op)
            3'd0: begin t = a + b; r = t[15:0]; c = t[16]; end
            3'd3: begin t = a + {16'h0, ~b} + 1; r = t[15:0]; c = t[16]; end
            3'd1: r = a;
            3'd2: r = a | b;
            3'd6: r = a & b;
            3'd4: begin t = {16'h0, a} << b[1:0]; r = t[15:0]; end
            3'd5: begin t = a * b; r = t[15:0]; end
            default: r = 16'h0;
        endcase
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Reference model: move the pending value on, then take in new inputs.
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            exp_res = 0; exp_c = 0; exp_tag = "R1";
            pend_res = 0; pend_c = 0; pend_tag = "R1";
        end else begin
            exp_res = pend_res; exp_c = pend_c; exp_tag = pend_tag;
            model(op_in, a_in, b_in, pend_res, pend_c);
            pend_tag = tag_of(op_in);
        end
    end

    // Compare the outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (started && !finished) begin
            chk(result_q == exp_res, exp_tag, result_q, exp_res);
            chk(carry_q == exp_c, (exp_tag == "R3" || exp_tag == "R4") ? exp_tag : "R11",
                carry_q, exp_c);
        end
    end

    task automatic step(input bit [2:0] op, input bit [15:0] a, input bit [15:0] b);
        @(negedge clk);
        op_in = op; a_in = a; b_in = b;
    endtask

    initial begin
        bit [31:0] lfsr;
        lfsr = 32'h1ACE_B00C;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: an answer is not visible one edge early
        step(3'd7, 16'hFFFF, 16'hFFFF);
        step(3'd1, 16'h1234, 16'h0);
        @(negedge clk);
        chk(result_q == 16'h0, "R2", result_q, 0);
        op_in = 3'd7;
        @(negedge clk);
        chk(result_q == 16'h1234, "R2", result_q, 16'h1234);
        // Directed corner cases: operations issued back to back
        step(3'd0, 16'h7FFF, 16'h0001);   // R3: 0x8000, carry 0
        step(3'd0, 16'hFFFF, 16'h0001);   // R3: 0x0000, carry 1
        step(3'd3, 16'h1234, 16'h1234);   // R4: equal operands
        step(3'd3, 16'h0005, 16'h0006);   // R4: borrow
        step(3'd3, 16'h0006, 16'h0005);   // R4
        step(3'd1, 16'hA5A5, 16'hFFFF);   // R5
        step(3'd2, 16'hF000, 16'h000F);   // R6
        step(3'd6, 16'hFF00, 16'h0FF0);   // R7
        step(3'd4, 16'h8001, 16'hFFFE);   // R8: shift by 2
        step(3'd4, 16'hFFFF, 16'h0003);   // R8: shift by 3
        step(3'd4, 16'h1234, 16'hFFFC);   // R8: shift by 0
        step(3'd5, 16'h0100, 16'h0100);   // R9: truncated to zero
        step(3'd5, 16'hFFFF, 16'hFFFF);   // R9: low half 0x0001
        step(3'd5, 16'h0123, 16'h0045);   // R9
        step(3'd7, 16'hFFFF, 16'hFFFF);   // R10
        // Pseudo-random stream with a reset pulse in the middle
        for (int i = 0; i < 400; i++) begin
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            step(lfsr[2:0], lfsr[18:3], lfsr[31:16]);
            rst_n = (i != 200);   // R1: reset in mid stream
        end
        step(3'd7, 16'h0, 16'h0);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 100000);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule